// File: doc/BRIEF.md
# Iterative Quadratic-Rotation Block Cipher Core

This core encrypts or decrypts one 128-bit block. The block is held as four 32-bit working words. Each round takes two of the words and puts each through a squaring-style map, x·(2x+1) modulo 2^32, followed by a fixed left rotation by 5. The results give two rotation amounts that depend on the data. The amounts are applied crosswise to the other two words. A round key is then added to each of those words, and the four words rotate one position in the bank. Decryption runs the inverse steps in reverse order. Key whitening comes before the 20 rounds and after them. The core never expands keys itself. It reads a prepared table of 44 round-key words through an external port that returns two words per read.

One step completes on each clock: a whitening step, twenty rounds, then a final whitening step. A block therefore occupies the core for 22 cycles. The core fetches key pairs one cycle ahead of use, in ascending order for encryption and descending order for decryption. While the core is idle, the key address already points at the first pair that the mode on the mode input would need. This lets the first step use its keys on the cycle right after the block is accepted.

Top module: `qc_block_core`

## Requirements
- R1: After a synchronous reset, `done_o` is low and `result_o` is all zeros until the first block finishes.
- R2: The block is packed little-endian. Byte k of the block occupies bits 8k+7:8k. Word A is bits 31:0, B is 63:32, C is 95:64 and D is 127:96. The result uses the same packing.
- R3: With `decrypt_i` low, the result equals pre-whitening (B += S[0], D += S[1]), then 20 forward rounds, then post-whitening (A += S[42], C += S[43]).
- R4: With `decrypt_i` high, the result is the exact inverse of R3 under the same key table, so decrypting an encrypted block returns the original block.
- R5: `done_o` goes high for exactly one cycle, 22 cycles after the clock edge that accepted `start_i`. `result_o` is valid in that cycle. A start held through the done cycle is accepted again at once, so two done pulses are 23 cycles apart.
- R6: `start_i`, `decrypt_i` and `block_i` are ignored while a block is in progress. The running block's result is unchanged.
- R7: `rk_addr_o` selects key pair p (words S[2p] in bits 31:0 and S[2p+1] in bits 63:32 of `rk_data_i`, returned one cycle later). When idle, it shows 0 for encrypt or 21 for decrypt, following `decrypt_i`. While busy at step s (s = 0..20), it shows s+1 when encrypting and 20−s when decrypting.
- R8: `result_o` holds its value in every cycle in which `done_o` is low.
- R9: With the table expanded from an all-zero 16-byte key and an all-zero block, encryption yields the bytes 8f c3 a5 36 56 b1 f7 78 c1 29 df 4e 98 48 a4 1e, first byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a block; accepted only while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled with start |
| block_i | input | 128 | Input block, packed per R2 |
| rk_addr_o | output | 5 | Round-key pair address |
| rk_data_i | input | 64 | Key pair read one cycle after the address |
| result_o | output | 128 | Registered result, packed per R2 |
| done_o | output | 1 | One-cycle pulse when `result_o` is new |

## Verification
The bench targets the edges of the step sequence. A core that applied the first whitening a cycle late, or used its keys off by one pair, would fail the known-answer vector and the reference comparison. A swapped rotation direction or a swapped crosswise amount would still pass encryption but break the decrypt-after-encrypt round trip. A start pulse with a different mode and block partway through a block checks that a busy core cannot restart or change direction; getting this wrong corrupts the result or moves the done pulse. Holding start high through the done cycle checks back-to-back acceptance. The key address is compared on every cycle, including the idle cycles where the mode input alone decides it, so an address one cycle behind the data would be caught.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_ROUND = 2'd1,
    PH_POST  = 2'd2
  } phase_e;
endpackage

// File: rtl/qc_mixfn.sv
// Quadratic word map x*(2x+1) mod 2^W, then a fixed left rotation by LGW.
module qc_mixfn #(
  parameter int W   = 32,
  parameter int LGW = 5
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] odd;
  logic [W-1:0] prod;

  assign odd  = {x[W-2:0], 1'b1};
  assign prod = x * odd;                 // low half only
  assign y    = {prod[W-1-LGW:0], prod[W-1:W-LGW]};
endmodule

// File: rtl/qc_barrel.sv
// Logarithmic rotator: fixed depth regardless of the amount.
module qc_barrel #(
  parameter int W    = 32,
  parameter int LGW  = 5,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]   x,
  input  logic [LGW-1:0] amt,
  output logic [W-1:0]   y
);
  logic [W-1:0] st [0:LGW];

  assign st[0] = x;

  for (genvar k = 0; k < LGW; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [W-1:0] rot;
    if (LEFT) begin : g_left
      assign rot = {st[k][W-1-SH:0], st[k][W-1:W-SH]};
    end else begin : g_right
      assign rot = {st[k][SH-1:0], st[k][W-1:SH]};
    end
    assign st[k+1] = amt[k] ? rot : st[k];
  end

  assign y = st[LGW];
endmodule

// File: rtl/qc_step.sv
// One combinational step: whitening or a round, in either direction.
module qc_step #(
  parameter int W   = 32,
  parameter int LGW = 5
) (
  input  qc_pkg::phase_e phase_i,
  input  logic           dec_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   c_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   k_lo_i,
  input  logic [W-1:0]   k_hi_i,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o,
  output logic [W-1:0]   c_o,
  output logic [W-1:0]   d_o
);
  import qc_pkg::*;

  logic [W-1:0] t_src, u_src, t_w, u_w;
  logic [W-1:0] fa_w, fc_w, ra_in, rc_in, ra_w, rc_w;

  // Decrypt sees the bank after the backward rotation, so its B and D
  // are the stored a and c.
  assign t_src = dec_i ? a_i : b_i;
  assign u_src = dec_i ? c_i : d_i;

  qc_mixfn #(.W(W), .LGW(LGW)) u_mix_t (.x(t_src), .y(t_w));
  qc_mixfn #(.W(W), .LGW(LGW)) u_mix_u (.x(u_src), .y(u_w));

  qc_barrel #(.W(W), .LGW(LGW), .LEFT(1'b1)) u_fwd_a (
    .x(a_i ^ t_w), .amt(u_w[LGW-1:0]), .y(fa_w));
  qc_barrel #(.W(W), .LGW(LGW), .LEFT(1'b1)) u_fwd_c (
    .x(c_i ^ u_w), .amt(t_w[LGW-1:0]), .y(fc_w));

  assign ra_in = d_i - k_lo_i;
  assign rc_in = b_i - k_hi_i;

  qc_barrel #(.W(W), .LGW(LGW), .LEFT(1'b0)) u_inv_a (
    .x(ra_in), .amt(u_w[LGW-1:0]), .y(ra_w));
  qc_barrel #(.W(W), .LGW(LGW), .LEFT(1'b0)) u_inv_c (
    .x(rc_in), .amt(t_w[LGW-1:0]), .y(rc_w));

  always_comb begin
    a_o = a_i;
    b_o = b_i;
    c_o = c_i;
    d_o = d_i;
    unique case (phase_i)
      PH_PRE: begin
        if (dec_i) begin
          a_o = a_i - k_lo_i;
          c_o = c_i - k_hi_i;
        end else begin
          b_o = b_i + k_lo_i;
          d_o = d_i + k_hi_i;
        end
      end
      PH_ROUND: begin
        if (dec_i) begin
          a_o = ra_w ^ t_w;
          b_o = a_i;
          c_o = rc_w ^ u_w;
          d_o = c_i;
        end else begin
          a_o = b_i;
          b_o = fc_w + k_hi_i;
          c_o = d_i;
          d_o = fa_w + k_lo_i;
        end
      end
      PH_POST: begin
        if (dec_i) begin
          b_o = b_i - k_lo_i;
          d_o = d_i - k_hi_i;
        end else begin
          a_o = a_i + k_lo_i;
          c_o = c_i + k_hi_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qc_ctrl.sv
// Step sequencer and key-pair address generator.
module qc_ctrl #(
  parameter int PAIRS = 22,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          decrypt_i,
  output logic          busy_o,
  output logic          dec_o,
  output logic          done_o,
  output logic          load_o,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(PAIRS - 1);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic          busy_q, dec_q, done_q;
  logic [AW-1:0] step_q;

  assign load_o = start_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        dec_q  <= decrypt_i;
        step_q <= '0;
      end else if (busy_q) begin
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + ONE;
        end
      end
    end
  end

  // Address leads use by one cycle to cover the table's read latency.
  always_comb begin
    if (!busy_q)
      addr_o = decrypt_i ? LAST : '0;
    else if (step_q == LAST)
      addr_o = '0;
    else if (dec_q)
      addr_o = LAST - ONE - step_q;
    else
      addr_o = step_q + ONE;
  end

  assign busy_o = busy_q;
  assign dec_o  = dec_q;
  assign done_o = done_q;
  assign step_o = step_q;

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && $past(step_q) == LAST));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && step_q != LAST) |=>
      (busy_q && step_q == $past(step_q) + ONE && dec_q == $past(dec_q)));

  assert_addr_ascend_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !dec_q && step_q < LAST - ONE) |=> (addr_o == $past(addr_o) + ONE));

  assert_addr_descend_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dec_q && step_q < LAST - ONE) |=> (addr_o == $past(addr_o) - ONE));
endmodule

// File: rtl/qc_block_core.sv
module qc_block_core #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic                         decrypt_i,
  input  logic [4*WORD_W-1:0]          block_i,
  output logic [$clog2(ROUNDS+2)-1:0]  rk_addr_o,
  input  logic [2*WORD_W-1:0]          rk_data_i,
  output logic [4*WORD_W-1:0]          result_o,
  output logic                         done_o
);
  import qc_pkg::*;

  localparam int PAIRS = ROUNDS + 2;
  localparam int AW    = $clog2(PAIRS);
  localparam int LGW   = $clog2(WORD_W);
  localparam logic [AW-1:0] LAST = AW'(PAIRS - 1);

  logic          busy, dec, load;
  logic [AW-1:0] step;
  phase_e        phase;

  logic [WORD_W-1:0] a_q, b_q, c_q, d_q;
  logic [WORD_W-1:0] a_n, b_n, c_n, d_n;
  logic [4*WORD_W-1:0] res_q;

  qc_ctrl #(.PAIRS(PAIRS), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .decrypt_i(decrypt_i),
    .busy_o   (busy),
    .dec_o    (dec),
    .done_o   (done_o),
    .load_o   (load),
    .step_o   (step),
    .addr_o   (rk_addr_o)
  );

  always_comb begin
    if (step == '0)       phase = PH_PRE;
    else if (step == LAST) phase = PH_POST;
    else                  phase = PH_ROUND;
  end

  qc_step #(.W(WORD_W), .LGW(LGW)) u_step (
    .phase_i(phase),
    .dec_i  (dec),
    .a_i    (a_q),
    .b_i    (b_q),
    .c_i    (c_q),
    .d_i    (d_q),
    .k_lo_i (rk_data_i[WORD_W-1:0]),
    .k_hi_i (rk_data_i[2*WORD_W-1:WORD_W]),
    .a_o    (a_n),
    .b_o    (b_n),
    .c_o    (c_n),
    .d_o    (d_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      d_q   <= '0;
      res_q <= '0;
    end else if (load) begin
      a_q <= block_i[WORD_W-1:0];
      b_q <= block_i[2*WORD_W-1:WORD_W];
      c_q <= block_i[3*WORD_W-1:2*WORD_W];
      d_q <= block_i[4*WORD_W-1:3*WORD_W];
    end else if (busy) begin
      a_q <= a_n;
      b_q <= b_n;
      c_q <= c_n;
      d_q <= d_n;
      if (step == LAST) res_q <= {d_n, c_n, b_n, a_n};
    end
  end

  assign result_o = res_q;

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy);
endmodule

// File: tb/qc_block_core_tb_top.sv
`timescale 1ns/1ps
module qc_block_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] block_i = '0;
  logic [4:0]   rk_addr_o;
  logic [63:0]  rk_data_i = '0;
  logic [127:0] result_o;
  logic         done_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] S [0:43];

  always #2 clk = ~clk;

  qc_block_core dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .block_i(block_i), .rk_addr_o(rk_addr_o), .rk_data_i(rk_data_i),
    .result_o(result_o), .done_o(done_o));

  // Key table with a registered dual-word read.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rk_addr_o < 5'd22)
      rk_data_i <= {S[2*rk_addr_o+1], S[2*rk_addr_o]};
    else
      rk_data_i <= '0;
  end

  function automatic logic [31:0] rl(input logic [31:0] x, input logic [31:0] amt);
    int n = int'(amt[4:0]);
    if (n == 0) return x;
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] x, input logic [31:0] amt);
    int n = int'(amt[4:0]);
    if (n == 0) return x;
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] fq(input logic [31:0] x);
    logic [31:0] p;
    p = x * ((x << 1) + 32'd1);
    return rl(p, 32'd5);
  endfunction

  function automatic logic [127:0] enc_ref(input logic [127:0] pt);
    logic [31:0] A, B, C, D, t, u, tmp;
    A = pt[31:0]; B = pt[63:32]; C = pt[95:64]; D = pt[127:96];
    B = B + S[0]; D = D + S[1];
    for (int i = 1; i <= 20; i++) begin
      t = fq(B); u = fq(D);
      A = rl(A ^ t, u) + S[2*i];
      C = rl(C ^ u, t) + S[2*i+1];
      tmp = A; A = B; B = C; C = D; D = tmp;
    end
    A = A + S[42]; C = C + S[43];
    return {D, C, B, A};
  endfunction

  function automatic logic [127:0] dec_ref(input logic [127:0] ct);
    logic [31:0] A, B, C, D, t, u, tmp;
    A = ct[31:0]; B = ct[63:32]; C = ct[95:64]; D = ct[127:96];
    C = C - S[43]; A = A - S[42];
    for (int i = 20; i >= 1; i--) begin
      tmp = D; D = C; C = B; B = A; A = tmp;
      u = fq(D); t = fq(B);
      C = rr(C - S[2*i+1], t) ^ u;
      A = rr(A - S[2*i], u) ^ t;
    end
    D = D - S[1]; B = B - S[0];
    return {D, C, B, A};
  endfunction

  task automatic expand_key(input logic [31:0] k0, k1, k2, k3);
    logic [31:0] L [0:3];
    logic [31:0] x, y;
    int i, j;
    L[0] = k0; L[1] = k1; L[2] = k2; L[3] = k3;
    S[0] = 32'hB7E15163;
    for (int n = 1; n < 44; n++) S[n] = S[n-1] + 32'h9E3779B9;
    x = 0; y = 0; i = 0; j = 0;
    for (int n = 0; n < 132; n++) begin
      S[i] = rl(S[i] + x + y, 32'd3); x = S[i];
      L[j] = rl(L[j] + x + y, x + y); y = L[j];
      i = (i + 1) % 44; j = (j + 1) % 4;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Cycle-level reference model.
  int mcnt = 0;
  bit mdone = 1'b0;
  bit mdec = 1'b0;
  logic [127:0] mexp = '0;
  logic [127:0] mres = '0;

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; mdone = 1'b0; mres = '0;
    end else begin
      mdone = 1'b0;
      if (mcnt == 0) begin
        if (start_i) begin
          mcnt = 22;
          mdec = decrypt_i;
          mexp = decrypt_i ? dec_ref(block_i) : enc_ref(block_i);
        end
      end else begin
        mcnt--;
        if (mcnt == 0) begin
          mdone = 1'b1;
          mres = mexp;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(done_o === mdone, "R5 done timing", 128'(done_o), 128'(mdone));
      if (mdone)
        chk(result_o === mres, mdec ? "R4 decrypt vs model" : "R3 encrypt vs model", result_o, mres);
      else
        chk(result_o === mres, "R8 R1 result held", result_o, mres);
      if (mcnt == 0)
        chk(rk_addr_o === (decrypt_i ? 5'd21 : 5'd0), "R7 idle address",
            128'(rk_addr_o), 128'(decrypt_i ? 5'd21 : 5'd0));
      else if (22 - mcnt < 21)
        chk(rk_addr_o === 5'(mdec ? 20 - (22 - mcnt) : (22 - mcnt) + 1), "R7 busy address",
            128'(rk_addr_o), 128'(mdec ? 20 - (22 - mcnt) : (22 - mcnt) + 1));
    end
  end

  task automatic go(input logic dec, input logic [127:0] blk);
    @(posedge clk); #1;
    start_i = 1'b1; decrypt_i = dec; block_i = blk;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  localparam logic [127:0] KAT = 128'h1ea44898_4edf29c1_78f7b156_36a5c38f;

  initial begin
    logic [127:0] pt, ct;
    int c1;
    expand_key(32'd0, 32'd0, 32'd0, 32'd0);
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(done_o === 1'b0 && result_o === '0, "R1 reset state", result_o, '0);

    // Known answer, and its inverse.
    go(1'b0, '0); wait_done();
    chk(result_o === KAT, "R9 R2 known-answer ciphertext", result_o, KAT);
    go(1'b1, KAT); wait_done();
    chk(result_o === '0, "R4 known-answer decrypt", result_o, '0);

    // Several keys and block patterns, with round trips.
    for (int n = 0; n < 8; n++) begin
      expand_key($urandom, $urandom, $urandom, $urandom);
      case (n)
        0: pt = '1;
        1: pt = 128'h1;
        2: pt = 128'h80000000_00000000_00000000_00000000;
        3: pt = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        default: pt = {$urandom, $urandom, $urandom, $urandom};
      endcase
      go(1'b0, pt); wait_done();
      ct = result_o;
      chk(ct === enc_ref(pt), "R3 encrypt pattern", ct, enc_ref(pt));
      go(1'b1, ct); wait_done();
      chk(result_o === pt, "R4 round trip", result_o, pt);
    end

    // Start with other mode and data while busy must be ignored.
    pt = {$urandom, $urandom, $urandom, $urandom};
    go(1'b0, pt);
    repeat (6) @(posedge clk);
    #1 start_i = 1'b1; decrypt_i = 1'b1; block_i = ~pt;
    @(posedge clk); #1 start_i = 1'b0; decrypt_i = 1'b0;
    wait_done();
    chk(result_o === enc_ref(pt), "R6 busy start ignored", result_o, enc_ref(pt));

    // Start held high: back-to-back blocks, 23 cycles apart.
    pt = {$urandom, $urandom, $urandom, $urandom};
    @(posedge clk); #1;
    start_i = 1'b1; decrypt_i = 1'b0; block_i = pt;
    wait_done();
    c1 = cyc;
    chk(result_o === enc_ref(pt), "R5 first back-to-back result", result_o, enc_ref(pt));
    wait_done();
    chk(cyc - c1 == 23, "R5 back-to-back spacing", 128'(cyc - c1), 128'd23);
    #1 start_i = 1'b0;

    repeat (30) @(posedge clk);
    @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule